// File: doc/BRIEF.md
# Interrupt Source Configuration Bank

This block holds the configuration words for a group of interrupt sources and turns their pending inputs into interrupt requests for one CPU. Each source has two registers: a vector/priority word, which also carries a mask bit, and a destination word, which carries the critical-select bits. Software reaches the bank through a 32-bit port. Reads are combinational, and a write takes effect on the clock edge at which the write enable is high.

Every unmasked, pending source raises one of two level outputs. It raises the critical output when the destination bit for this CPU is set, and the normal output when that bit is clear. The parameter `CPU_ID` selects which CPU the instance serves, and so which critical-select bit it looks at. Accesses whose low four address bits are not zero are rejected. Accesses beyond the end of the window are also rejected. A rejected read returns all ones and a rejected write changes nothing.

Top module: `src_cfg_bank`

## Requirements
- R1: After reset, every vector/priority word reads 0x80800000 and every destination word reads 0x00000001. Both outputs are low while sources are masked.
- R2: Each source occupies a 32-byte slot, and the source index is the byte offset divided by 32. Offset bit 4 set selects the destination word and bit 4 clear selects the vector/priority word. A write changes only the addressed word.
- R3: An access with addr_i[3:0] not equal to zero reads 0xFFFFFFFF. A write to such an address changes no register.
- R4: An access at an offset of NUM_SRC*32 or above reads 0xFFFFFFFF. A write there changes no register and does not alias onto a lower slot.
- R5: In the vector/priority word, bit 31 (mask), bits 19:16 (priority) and bits 15:0 (vector) are writable. Every other bit keeps its reset value, so bit 23 reads 1 and the remaining bits read 0.
- R6: In the destination word, only bits 0, 1, 2, 30 and 31 are writable, and every other bit reads 0.
- R7: A pending source with bit 31 of its vector/priority word clear raises cirq_o when destination bit (1+CPU_ID) is set, and raises irq_o otherwise. The outputs are registered, so they change one clock after the input or register change.
- R8: A source with vector/priority bit 31 set raises neither output, whatever its pending input.
- R9: The outputs are levels. They stay high for as long as a qualifying source stays pending. They fall one clock after the pending input deasserts or after the source is masked.
- R10: With CPU_ID=1, destination bit 2 is the critical select and bit 1 has no effect on routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the word at addr_i |
| addr_i | input | ADDR_W | Byte offset within the bank |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| pend_i | input | NUM_SRC | Per-source pending levels |
| irq_o | output | 1 | Normal interrupt request |
| cirq_o | output | 1 | Critical interrupt request |

## Verification
The bench builds two instances with NUM_SRC=12 and ADDR_W=16, one with CPU_ID=0 and one with CPU_ID=1. Both instances share the same register traffic and pending inputs. A single destination write can therefore be seen to send a source to the critical output in one instance and to the normal output in the other. The 12-source build puts the window end at 0x180, so accesses at 0x180 and 0x190 test the out-of-window rejection against the first slot that does not exist. The 16-bit address leaves room above that boundary for those offsets.

// File: rtl/src_cfg_pkg.sv
package src_cfg_pkg;
  localparam logic [31:0] VP_RST    = 32'h8080_0000;
  localparam logic [31:0] DST_RST   = 32'h0000_0001;
  localparam logic [31:0] VP_WMASK  = 32'h800F_FFFF;
  localparam logic [31:0] DST_WMASK = 32'hC000_0007;
  localparam int          MASK_BIT  = 31;
  localparam int          CRIT_BIT0 = 1;
  localparam int          SLOT_SH   = 5;
endpackage

// File: rtl/src_cfg_decode.sv
module src_cfg_decode #(
  parameter int NUM_SRC = 12,
  parameter int ADDR_W  = 16,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              sel_dst_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(NUM_SRC * (1 << src_cfg_pkg::SLOT_SH));

  assign hit_o     = (addr_i[3:0] == 4'h0) && (addr_i < WIN_END);
  assign sel_dst_o = addr_i[4];
  assign idx_o     = addr_i[src_cfg_pkg::SLOT_SH +: IDX_W];
endmodule

// File: rtl/src_cfg_slot.sv
module src_cfg_slot #(
  parameter int CPU_ID = 0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        vp_we_i,
  input  logic        dst_we_i,
  input  logic [31:0] wdata_i,
  input  logic        pend_i,
  output logic [31:0] vp_o,
  output logic [31:0] dst_o,
  output logic        fire_n_o,
  output logic        fire_c_o
);
  import src_cfg_pkg::*;

  logic [31:0] vp_q, dst_q;
  logic        active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vp_q  <= VP_RST;
      dst_q <= DST_RST;
    end else begin
      if (vp_we_i)  vp_q  <= (wdata_i & VP_WMASK) | (vp_q & ~VP_WMASK);
      if (dst_we_i) dst_q <= wdata_i & DST_WMASK;
    end
  end

  assign active   = pend_i && !vp_q[MASK_BIT];
  assign fire_c_o = active &&  dst_q[CRIT_BIT0 + CPU_ID];
  assign fire_n_o = active && !dst_q[CRIT_BIT0 + CPU_ID];
  assign vp_o     = vp_q;
  assign dst_o    = dst_q;
endmodule

// File: rtl/src_cfg_route.sv
module src_cfg_route #(
  parameter int NUM_SRC = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] fire_n_i,
  input  logic [NUM_SRC-1:0] fire_c_i,
  output logic               irq_o,
  output logic               cirq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o  <= 1'b0;
      cirq_o <= 1'b0;
    end else begin
      irq_o  <= |fire_n_i;
      cirq_o <= |fire_c_i;
    end
  end
endmodule

// File: rtl/src_cfg_bank.sv
module src_cfg_bank #(
  parameter int NUM_SRC = 12,
  parameter int ADDR_W  = 16,
  parameter int CPU_ID  = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               irq_o,
  output logic               cirq_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic             hit, sel_dst;
  logic [IDX_W-1:0] idx;

  logic [NUM_SRC-1:0][31:0] vp_all, dst_all;
  logic [NUM_SRC-1:0]       mask_vec, fire_n, fire_c;

  src_cfg_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
    .addr_i   (addr_i),
    .hit_o    (hit),
    .sel_dst_o(sel_dst),
    .idx_o    (idx)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic sel;
    assign sel = wr_en_i && hit && (idx == IDX_W'(g));

    src_cfg_slot #(.CPU_ID(CPU_ID)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .vp_we_i (sel && !sel_dst),
      .dst_we_i(sel &&  sel_dst),
      .wdata_i (wdata_i),
      .pend_i  (pend_i[g]),
      .vp_o    (vp_all[g]),
      .dst_o   (dst_all[g]),
      .fire_n_o(fire_n[g]),
      .fire_c_o(fire_c[g])
    );
    assign mask_vec[g] = vp_all[g][src_cfg_pkg::MASK_BIT];
  end

  always_comb begin
    rdata_o = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (hit && idx == IDX_W'(i)) rdata_o = sel_dst ? dst_all[i] : vp_all[i];
    end
  end

  src_cfg_route #(.NUM_SRC(NUM_SRC)) u_route (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_n_i(fire_n),
    .fire_c_i(fire_c),
    .irq_o   (irq_o),
    .cirq_o  (cirq_o)
  );
endmodule

// File: rtl/src_cfg_bank_chk.sv
module src_cfg_bank_chk #(
  parameter int NUM_SRC = 12,
  parameter int ADDR_W  = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     wr_en_i,
  input logic [ADDR_W-1:0]        addr_i,
  input logic [31:0]              rdata_o,
  input logic [NUM_SRC-1:0]       pend_i,
  input logic                     irq_o,
  input logic                     cirq_o,
  input logic [NUM_SRC-1:0][31:0] vp_all,
  input logic [NUM_SRC-1:0][31:0] dst_all,
  input logic [NUM_SRC-1:0]       mask_vec
);
  localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(NUM_SRC * 32);

  a_r3_misalign_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[3:0] != 4'h0) |-> (rdata_o == 32'hFFFF_FFFF));

  a_r3_misalign_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[3:0] != 4'h0) |=> ($stable(vp_all) && $stable(dst_all)));

  a_r4_outwin_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= WIN_END) |-> (rdata_o == 32'hFFFF_FFFF));

  a_r4_outwin_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i >= WIN_END) |=> ($stable(vp_all) && $stable(dst_all)));

  a_r8_masked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & ~mask_vec) == '0) |=> (!irq_o && !cirq_o));

  a_r9_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |=> (!irq_o && !cirq_o));
endmodule

bind src_cfg_bank src_cfg_bank_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/src_cfg_bank_bench.sv
module src_cfg_bank_bench;
  localparam int NUM_SRC = 12;
  localparam int ADDR_W  = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0;
  logic [ADDR_W-1:0]  addr = '0;
  logic [31:0]        wdata = '0;
  logic [NUM_SRC-1:0] pend = '0;
  logic [31:0]        rdata0, rdata1;
  logic               irq0, cirq0, irq1, cirq1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  src_cfg_bank #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .CPU_ID(0)) u_src_cfg_bank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata0), .pend_i(pend), .irq_o(irq0), .cirq_o(cirq0));

  src_cfg_bank #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .CPU_ID(1)) u_src_cfg_bank_c1 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata1), .pend_i(pend), .irq_o(irq1), .cirq_o(cirq1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rdata0, exp);
    chk(req, rdata1, exp);
  endtask

  // expected order: {irq0, cirq0, irq1, cirq1}
  task automatic outs(input string req, input logic [3:0] exp);
    chk(req, {28'h0, irq0, cirq0, irq1, cirq1}, {28'h0, exp});
  endtask

  task automatic settle;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rd("R1 vp0", 16'h000, 32'h8080_0000);
    rd("R1 dst0", 16'h010, 32'h0000_0001);
    rd("R1 vp11", 16'h160, 32'h8080_0000);
    rd("R1 dst11", 16'h170, 32'h0000_0001);
    pend = 12'h020;
    settle(); settle();
    outs("R1 masked at reset", 4'b0000);
    pend = '0;
  endtask

  task automatic t_map;
    wr(16'h040, 32'h0003_0042);
    rd("R2 vp2 written", 16'h040, 32'h0083_0042);
    rd("R2 dst2 untouched", 16'h050, 32'h0000_0001);
    rd("R2 vp3 untouched", 16'h060, 32'h8080_0000);
    wr(16'h170, 32'h4000_0000);
    rd("R2 dst11 written", 16'h170, 32'h4000_0000);
    rd("R2 vp11 untouched", 16'h160, 32'h8080_0000);
  endtask

  task automatic t_vp_mask;
    wr(16'h000, 32'hFFFF_FFFF);
    rd("R5 vp all ones", 16'h000, 32'h808F_FFFF);
    wr(16'h000, 32'h0000_0000);
    rd("R5 vp zero", 16'h000, 32'h0080_0000);
    wr(16'h000, 32'h8000_0000);
    rd("R5 vp restore", 16'h000, 32'h8080_0000);
  endtask

  task automatic t_dst_mask;
    wr(16'h010, 32'hFFFF_FFFF);
    rd("R6 dst all ones", 16'h010, 32'hC000_0007);
    wr(16'h010, 32'h0000_0000);
    rd("R6 dst zero", 16'h010, 32'h0000_0000);
    wr(16'h010, 32'h0000_0001);
    rd("R6 dst restore", 16'h010, 32'h0000_0001);
  endtask

  task automatic t_misalign;
    wr(16'h044, 32'h1234_5678);
    wr(16'h054, 32'hFFFF_FFFF);
    rd("R3 vp2 kept", 16'h040, 32'h0083_0042);
    rd("R3 dst2 kept", 16'h050, 32'h0000_0001);
    rd("R3 misaligned read 44", 16'h044, 32'hFFFF_FFFF);
    rd("R3 misaligned read 08", 16'h008, 32'hFFFF_FFFF);
  endtask

  task automatic t_window;
    rd("R4 read 180", 16'h180, 32'hFFFF_FFFF);
    rd("R4 read 1F0", 16'h1F0, 32'hFFFF_FFFF);
    wr(16'h180, 32'h0000_0000);
    wr(16'h190, 32'h0000_0000);
    rd("R4 no alias vp0", 16'h000, 32'h8080_0000);
    rd("R4 no alias dst0", 16'h010, 32'h0000_0001);
  endtask

  task automatic t_route;
    @(negedge clk);
    pend = 12'h004;
    #1;
    outs("R7 one cycle latency", 4'b0000);
    settle();
    outs("R7 normal route", 4'b1010);
    wr(16'h050, 32'h0000_0002);
    settle();
    outs("R7 crit bit1 cpu0", 4'b0110);
    wr(16'h050, 32'h0000_0004);
    settle();
    outs("R10 crit bit2 cpu1", 4'b1001);
    wr(16'h080, 32'h0001_0010);
    wr(16'h090, 32'h0000_0006);
    pend = 12'h014;
    settle(); settle();
    outs("R7 two sources both outputs", 4'b1101);
    pend = 12'h004;
    settle(); settle();
  endtask

  task automatic t_mask;
    wr(16'h040, 32'h8003_0042);
    settle();
    outs("R8 masked source silent", 4'b0000);
    pend = 12'h024;
    settle(); settle();
    outs("R8 masked pending ignored", 4'b0000);
    pend = 12'h004;
  endtask

  task automatic t_level;
    wr(16'h050, 32'h0000_0001);
    wr(16'h040, 32'h0003_0042);
    settle();
    for (int k = 0; k < 3; k++) begin
      outs("R9 level held", 4'b1010);
      settle();
    end
    @(negedge clk);
    pend = '0;
    #1;
    outs("R9 still high before edge", 4'b1010);
    settle();
    outs("R9 low after release", 4'b0000);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_vp_mask();
    t_dst_mask();
    t_misalign();
    t_window();
    t_route();
    t_mask();
    t_level();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule